// File: doc/BRIEF.md
# Banked File Register Address Decoder

This block turns the 7-bit file address carried by an instruction into a 9-bit physical data-memory address and serves the access. The physical space is four banks of 128 locations. A two-bit bank field held in an internal status byte supplies the upper two address bits on direct accesses. General-purpose bytes live in an internal store. Special-function locations are handed to an external bus through a select strobe and the resolved physical address. The status byte and the pointer byte are the only special-function locations held inside the block.

The top sixteen offsets of every bank share one set of physical bytes, so these bytes can be reached without changing bank. Offset 00 holds no storage of its own. An access there is redirected through the pointer byte, and the top bit of the status byte supplies the ninth address bit. Reads are combinational from the current address and state. Writes take effect on the rising clock edge when the write enable is high.

Top module: `regbank_decoder`

## Requirements
- R1: After synchronous reset the status byte and the pointer byte both read 00, so bank 0 is selected and the indirect high bit is 0.
- R2: A direct access (offset not 00) resolves to physical address {status[6], status[5], offset}. Status bit 6 is the upper bank bit and bit 5 is the lower bank bit.
- R3: General-purpose bytes of different banks are separate storage. The general-purpose ranges are: bank 0 at offsets 20–7F, bank 1 at 20–6F, banks 2 and 3 at 10–7F.
- R4: Offsets 70–7F of banks 1, 2 and 3 reach the same bytes as offsets 70–7F of bank 0.
- R5: The status byte sits at offset 03 and the pointer byte at offset 04 in every bank. Both can be read and written there.
- R6: An access to offset 00 is redirected to physical address {status[7], pointer[7:0]}, for reads and for writes.
- R7: When the redirected address has offset 00 (pointer[6:0] = 0), a read returns 00, the select strobe stays low, and a write changes nothing.
- R8: The select strobe is high exactly for special-function offsets other than 00, 03 and 04: offsets 01–1F in banks 0 and 1, and 01–0F in banks 2 and 3. While it is high, the bus address output carries the resolved 9-bit physical address and the read data is the bus return data when the bus acknowledges.
- R9: A special-function read that the external bus does not acknowledge returns 00.
- R10: The select strobe is low for general-purpose, status, pointer and null-indirect accesses.
- R11: A write takes effect only at a clock edge with the write enable high. With the enable low, stored bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 7 | File address offset from the instruction |
| we | input | 1 | Write enable for the current access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current access |
| sfr_sel | output | 1 | High when the access targets an external special-function location |
| sfr_addr | output | 9 | Resolved physical address for the external bus |
| sfr_rdata | input | 8 | Read data returned by the external bus |
| sfr_ack | input | 1 | External bus reports the location as implemented |

## Verification
The hardest case to reach is the null indirect access. It needs the pointer to hold an offset of 00 while the status high bit chooses the upper half of the space. That takes a write to the status byte, then a write to the pointer, and only then a read and a write through offset 00. The bench follows that exact chain. Afterwards it reads back the status and pointer bytes and a shared byte, to show that the write went nowhere. Reaching the common region from bank 3 and reaching bank-2 storage through the ninth pointer bit also depend on earlier status writes. The vector table builds those states in order.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int DW      = 8;
    localparam int OFFW    = 7;
    localparam int BANKW   = 2;
    localparam int PAW     = OFFW + BANKW;
    localparam int GPR_N   = 368;
    localparam int GPRW    = $clog2(GPR_N);

    localparam logic [OFFW-1:0] OFF_IND    = 7'h00;
    localparam logic [OFFW-1:0] OFF_STAT   = 7'h03;
    localparam logic [OFFW-1:0] OFF_PTR    = 7'h04;
    localparam logic [OFFW-1:0] COMMON_LO  = 7'h70;
    localparam int              BIT_HIADR  = 7;
    localparam int              BIT_BANKHI = 6;
    localparam int              BIT_BANKLO = 5;

    typedef enum logic [2:0] {
        REG_NULL,
        REG_STAT,
        REG_PTR,
        REG_SFR,
        REG_GPR
    } region_e;

    typedef struct packed {
        region_e           kind;
        logic [GPRW-1:0]   gidx;
        logic [PAW-1:0]    phys;
    } decode_t;

    // first offset past the special-function window of a bank
    function automatic logic [OFFW-1:0] sfr_limit(input logic [BANKW-1:0] bank);
        return (bank < 2'd2) ? 7'h20 : 7'h10;
    endfunction

    // storage index of the first banked general-purpose byte
    function automatic logic [GPRW-1:0] gpr_base(input logic [BANKW-1:0] bank);
        case (bank)
            2'd0:    return 9'd0;
            2'd1:    return 9'd96;
            2'd2:    return 9'd176;
            default: return 9'd272;
        endcase
    endfunction

    function automatic decode_t classify(input logic [PAW-1:0] phys);
        decode_t          d;
        logic [BANKW-1:0] bank;
        logic [OFFW-1:0]  off;
        bank   = phys[PAW-1:OFFW];
        off    = phys[OFFW-1:0];
        d.phys = phys;
        d.gidx = '0;
        if (off == OFF_IND) begin
            d.kind = REG_NULL;
        end else if (off == OFF_STAT) begin
            d.kind = REG_STAT;
        end else if (off == OFF_PTR) begin
            d.kind = REG_PTR;
        end else if (off >= COMMON_LO) begin
            d.kind = REG_GPR;
            d.gidx = {2'b00, off} - 9'h020;
        end else if (off < sfr_limit(bank)) begin
            d.kind = REG_SFR;
        end else begin
            d.kind = REG_GPR;
            d.gidx = gpr_base(bank) + {2'b00, off} - {2'b00, sfr_limit(bank)};
        end
        return d;
    endfunction
endpackage

// File: rtl/bank_addr_mux.sv
module bank_addr_mux
    import regbank_pkg::*;
(
    input  logic [OFFW-1:0] offset,
    input  logic [DW-1:0]   status,
    input  logic [DW-1:0]   ptr,
    output logic [PAW-1:0]  phys
);
    always_comb begin
        if (offset == OFF_IND)
            phys = {status[BIT_HIADR], ptr};
        else
            phys = {status[BIT_BANKHI], status[BIT_BANKLO], offset};
    end
endmodule

// File: rtl/region_decode.sv
module region_decode
    import regbank_pkg::*;
(
    input  logic [PAW-1:0] phys,
    output decode_t        dec
);
    always_comb dec = classify(phys);
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
    parameter int DEPTH = 368,
    parameter int WIDTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wen,
    input  logic [IW-1:0]    idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wen)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/regbank_decoder.sv
module regbank_decoder
    import regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [6:0]      addr,
    input  logic            we,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    output logic            sfr_sel,
    output logic [8:0]      sfr_addr,
    input  logic [7:0]      sfr_rdata,
    input  logic            sfr_ack
);
    logic [DW-1:0]  status_q;
    logic [DW-1:0]  ptr_q;
    logic [PAW-1:0] phys;
    decode_t        dec;
    logic [DW-1:0]  gpr_rd;
    logic           gpr_wen;

    bank_addr_mux u_mux (
        .offset (addr),
        .status (status_q),
        .ptr    (ptr_q),
        .phys   (phys)
    );

    region_decode u_dec (
        .phys (phys),
        .dec  (dec)
    );

    assign gpr_wen = we && (dec.kind == REG_GPR);

    gpr_store #(.DEPTH(GPR_N), .WIDTH(DW)) u_gpr (
        .clk   (clk),
        .wen   (gpr_wen),
        .idx   (dec.gidx),
        .wdata (wdata),
        .rdata (gpr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            ptr_q    <= '0;
        end else if (we) begin
            if (dec.kind == REG_STAT) status_q <= wdata;
            if (dec.kind == REG_PTR)  ptr_q    <= wdata;
        end
    end

    always_comb begin
        case (dec.kind)
            REG_STAT: rdata = status_q;
            REG_PTR:  rdata = ptr_q;
            REG_SFR:  rdata = sfr_ack ? sfr_rdata : '0;
            REG_GPR:  rdata = gpr_rd;
            default:  rdata = '0;
        endcase
    end

    assign sfr_sel  = (dec.kind == REG_SFR);
    assign sfr_addr = dec.phys;
endmodule

// File: rtl/regbank_decoder_chk.sv
module regbank_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic [6:0] addr,
    input logic       we,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       sfr_sel,
    input logic [8:0] sfr_addr,
    input logic       sfr_ack,
    input logic [7:0] status_q,
    input logic [7:0] ptr_q
);
    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d)
            p_reset_clear_r1: assert (status_q == 8'h00 && ptr_q == 8'h00);
    end

    p_direct_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (sfr_sel && addr != 7'h00) |-> sfr_addr == {status_q[6:5], addr});

    p_indirect_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (sfr_sel && addr == 7'h00) |-> sfr_addr == {status_q[7], ptr_q});

    p_null_read_r7: assert property (@(posedge clk) disable iff (rst)
        (addr == 7'h00 && ptr_q[6:0] == 7'h00) |-> (rdata == 8'h00 && !sfr_sel));

    p_null_write_r7: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 7'h00 && ptr_q[6:0] == 7'h00) |=> ($stable(status_q) && $stable(ptr_q)));

    p_sfr_window_r8: assert property (@(posedge clk) disable iff (rst)
        sfr_sel |-> (sfr_addr[6:0] != 7'h00 && sfr_addr[6:0] != 7'h03 && sfr_addr[6:0] != 7'h04
                     && sfr_addr[6:0] < (sfr_addr[8] ? 7'h10 : 7'h20)));

    p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (sfr_sel && !sfr_ack) |-> rdata == 8'h00);

    p_no_sel_core_r10: assert property (@(posedge clk) disable iff (rst)
        (addr == 7'h03 || addr == 7'h04) |-> !sfr_sel);

    p_status_write_r11: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 7'h03) |=> status_q == $past(wdata));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(status_q) && $stable(ptr_q)));
endmodule

bind regbank_decoder regbank_decoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .we       (we),
    .wdata    (wdata),
    .rdata    (rdata),
    .sfr_sel  (sfr_sel),
    .sfr_addr (sfr_addr),
    .sfr_ack  (sfr_ack),
    .status_q (status_q),
    .ptr_q    (ptr_q)
);

// File: tb/regbank_decoder_tb.sv
module regbank_decoder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sfr_sel;
    logic [8:0] sfr_addr;
    logic [7:0] sfr_rdata = 8'h5A;
    logic       sfr_ack = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    regbank_decoder u_dut (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .we        (we),
        .wdata     (wdata),
        .rdata     (rdata),
        .sfr_sel   (sfr_sel),
        .sfr_addr  (sfr_addr),
        .sfr_rdata (sfr_rdata),
        .sfr_ack   (sfr_ack)
    );

    // {we, addr, wdata, ack, check_rdata, exp_rdata, exp_sel, exp_sfr_addr, tag}
    typedef logic [43:0] vec_t;
    function automatic vec_t v(input logic w, input logic [6:0] a, input logic [7:0] d,
                               input logic k, input logic c, input logic [7:0] e,
                               input logic s, input logic [8:0] sa, input logic [7:0] tag);
        return {w, a, d, k, c, e, s, sa, tag};
    endfunction

    localparam int NV = 40;
    localparam vec_t VEC [NV] = '{
        v(0, 7'h03, 8'h00, 0, 1, 8'h00, 0, 9'h000, 8'd1),   // R1 status 00
        v(0, 7'h04, 8'h00, 0, 1, 8'h00, 0, 9'h000, 8'd1),   // R1 pointer 00
        v(1, 7'h20, 8'h11, 0, 0, 8'h00, 0, 9'h000, 8'd3),
        v(1, 7'h75, 8'h77, 0, 0, 8'h00, 0, 9'h000, 8'd4),
        v(0, 7'h20, 8'h00, 0, 1, 8'h11, 0, 9'h000, 8'd3),   // R3 bank0 byte
        v(0, 7'h05, 8'h00, 1, 1, 8'h5A, 1, 9'h005, 8'd8),   // R8
        v(0, 7'h06, 8'h00, 0, 1, 8'h00, 1, 9'h006, 8'd9),   // R9
        v(1, 7'h03, 8'h20, 0, 0, 8'h00, 0, 9'h000, 8'd2),   // bank 1
        v(0, 7'h03, 8'h00, 0, 1, 8'h20, 0, 9'h000, 8'd5),   // R5
        v(1, 7'h20, 8'h22, 0, 0, 8'h00, 0, 9'h000, 8'd3),
        v(0, 7'h20, 8'h00, 0, 1, 8'h22, 0, 9'h000, 8'd3),   // R3 bank1 byte
        v(0, 7'h75, 8'h00, 0, 1, 8'h77, 0, 9'h000, 8'd4),   // R4 via bank1
        v(0, 7'h1F, 8'h00, 1, 1, 8'h5A, 1, 9'h09F, 8'd2),   // R2/R8
        v(0, 7'h70, 8'h00, 0, 0, 8'h00, 0, 9'h000, 8'd10),  // R10 common
        v(1, 7'h03, 8'h40, 0, 0, 8'h00, 0, 9'h000, 8'd2),   // bank 2
        v(0, 7'h75, 8'h00, 0, 1, 8'h77, 0, 9'h000, 8'd4),   // R4 via bank2
        v(1, 7'h10, 8'h33, 0, 0, 8'h00, 0, 9'h000, 8'd3),
        v(0, 7'h10, 8'h00, 0, 1, 8'h33, 0, 9'h000, 8'd3),   // R3 bank2 byte
        v(0, 7'h0F, 8'h00, 1, 1, 8'h5A, 1, 9'h10F, 8'd8),   // R8 bank2 edge
        v(1, 7'h03, 8'h60, 0, 0, 8'h00, 0, 9'h000, 8'd2),   // bank 3
        v(0, 7'h05, 8'h00, 1, 1, 8'h5A, 1, 9'h185, 8'd2),   // R2
        v(0, 7'h04, 8'h00, 0, 1, 8'h00, 0, 9'h000, 8'd5),   // R5 ptr in bank3
        v(0, 7'h75, 8'h00, 0, 1, 8'h77, 0, 9'h000, 8'd4),   // R4 via bank3
        v(1, 7'h04, 8'hA0, 0, 0, 8'h00, 0, 9'h000, 8'd5),
        v(1, 7'h03, 8'h00, 0, 0, 8'h00, 0, 9'h000, 8'd5),   // bank0, high bit 0
        v(0, 7'h00, 8'h00, 0, 1, 8'h22, 0, 9'h000, 8'd6),   // R6 -> 0A0
        v(1, 7'h04, 8'h20, 0, 0, 8'h00, 0, 9'h000, 8'd6),
        v(1, 7'h00, 8'h44, 0, 0, 8'h00, 0, 9'h000, 8'd6),
        v(0, 7'h20, 8'h00, 0, 1, 8'h44, 0, 9'h000, 8'd6),   // R6 indirect write
        v(0, 7'h20, 8'hFF, 0, 1, 8'h44, 0, 9'h000, 8'd11),  // R11 we low
        v(0, 7'h20, 8'h00, 0, 1, 8'h44, 0, 9'h000, 8'd11),  // R11 still held
        v(1, 7'h03, 8'h80, 0, 0, 8'h00, 0, 9'h000, 8'd6),   // high addr bit 1
        v(1, 7'h04, 8'h10, 0, 0, 8'h00, 0, 9'h000, 8'd6),
        v(0, 7'h00, 8'h00, 0, 1, 8'h33, 0, 9'h000, 8'd6),   // R6 -> 110
        v(1, 7'h04, 8'h80, 0, 0, 8'h00, 0, 9'h000, 8'd7),
        v(0, 7'h00, 8'h00, 1, 1, 8'h00, 0, 9'h000, 8'd7),   // R7 null read
        v(1, 7'h00, 8'h99, 1, 0, 8'h00, 0, 9'h000, 8'd7),   // R7 null write
        v(0, 7'h03, 8'h00, 0, 1, 8'h80, 0, 9'h000, 8'd7),   // R7 status kept
        v(0, 7'h04, 8'h00, 0, 1, 8'h80, 0, 9'h000, 8'd7),   // R7 pointer kept
        v(0, 7'h75, 8'h00, 0, 1, 8'h77, 0, 9'h000, 8'd7)    // R7 shared kept
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [6:0] a, input logic [7:0] d, input logic k);
        @(negedge clk);
        we = w; addr = a; wdata = d; sfr_ack = k;
        #1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t   x;
            string  tag;
            x = VEC[i];
            tag = $sformatf("R%0d vec%0d", x[7:0], i);
            access(x[43], x[42:36], x[35:28], x[27]);
            if (x[26]) check({tag, " rdata"}, {8'h00, rdata}, {8'h00, x[25:18]});
            check({tag, " sfr_sel"}, {15'h0, sfr_sel}, {15'h0, x[17]});
            if (x[17]) check({tag, " sfr_addr"}, {7'h0, sfr_addr}, {7'h0, x[16:8]});
        end

        // R10: general-purpose, status and pointer never raise the strobe
        access(0, 7'h03, 8'h00, 1);
        check("R10 status", {15'h0, sfr_sel}, 16'h0);
        access(0, 7'h21, 8'h00, 1);
        check("R10 gpr", {15'h0, sfr_sel}, 16'h0);

        // R8: bank-2 window ends at 0F, 10 is storage
        access(1, 7'h03, 8'h40, 0);
        access(0, 7'h10, 8'h00, 1);
        check("R8 bank2 10 not sfr", {15'h0, sfr_sel}, 16'h0);
        check("R3 bank2 10 value", {8'h0, rdata}, 16'h0033);

        // R1: reset mid-run restores bank 0 and clears both bytes
        access(1, 7'h04, 8'h55, 0);
        @(negedge clk) rst = 1'b1; we = 1'b0;
        @(negedge clk) rst = 1'b0;
        access(0, 7'h03, 8'h00, 0);
        check("R1 status after reset", {8'h0, rdata}, 16'h0000);
        access(0, 7'h04, 8'h00, 0);
        check("R1 pointer after reset", {8'h0, rdata}, 16'h0000);
        access(0, 7'h20, 8'h00, 0);
        check("R1 bank0 selected", {8'h0, rdata}, 16'h0044);
        access(0, 7'h08, 8'h00, 1);
        check("R1 R2 sfr addr bank0", {7'h0, sfr_addr}, 16'h0008);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule